// File: doc/BRIEF.md
# Serial-Programmed Configuration Register Bank

This block is the device-side end of a four-wire serial configuration port (SS, SCK, MOSI, MISO). It holds a handful of 8-bit registers, and the settings decoded from them are driven on parallel outputs to the rest of the chip. The four serial inputs are brought into the system clock domain through synchronizer flops, and SCK edges are detected there. Because of this, SCK must run several times slower than `clk`.

A frame opens when SS falls. The first bit is a direction flag and the next seven bits are an address, both sent most significant bit first. A write frame then carries eight data bits, and the register is updated only after the sixteenth bit arrives. A read frame ends its header after eight bits. The slave then drives the addressed byte on MISO, beginning at the falling edge of the eighth clock. MISO is brought out as a data bit and an enable, so the pad ring can build the tri-state driver.

The register bank has five locations:
- Address 00h is a read-only status byte taken from an input port.
- Address 01h holds the output swing and common-mode offset codes.
- Address 02h holds the launch coarse select and the fine-trim code.
- Addresses 03h and 04h are plain 8-bit registers.

Top module: `spi_cfg_bank`

## Requirements
- R1: After reset, swing_code is 3'b011, offset_code is 3'b001, launch_coarse is 0, launch_fine is 4'b0000, and registers 03h and 04h hold 00h. Register 01h then reads 64h and register 02h reads 00h.
- R2: A write frame has 16 bits, each sampled on a rising SCK edge: bit 0 (write), then the address MSB first, then the data MSB first. After SS rises, register 01h bits [7:5] appear on swing_code and bits [4:2] appear on offset_code.
- R3: A read frame has the header bit 1 followed by the address. miso_oe stays low until the falling edge of the eighth SCK clock. From that edge until SS rises, miso_oe is high and miso_d presents the register MSB first, with a new bit on each falling edge.
- R4: miso_oe stays low for the whole of a write frame and whenever SS is high.
- R5: A swing field above 3'b100 leaves the stored swing code unchanged. An offset field above 3'b101 leaves the stored offset code unchanged. Each field is judged on its own, and bits [1:0] of register 01h read as 0.
- R6: In register 02h, bit 7 drives launch_coarse and bits [6:3] drive launch_fine. Bits [2:0] read as 0.
- R7: A read of address 00h returns the current value of status_in. A write to 00h has no effect.
- R8: A write to any address from 05h to 7Fh changes no register, and a read of such an address returns 00h.
- R9: If SS rises before the sixteenth bit of a write frame, no register changes.
- R10: Registers 03h and 04h store and return all eight bits written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ss_n | input | 1 | Slave select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data from the master |
| miso_d | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| status_in | input | 8 | Status byte returned at address 00h |
| swing_code | output | 3 | Output swing setting |
| offset_code | output | 3 | Output common-mode offset setting |
| launch_coarse | output | 1 | Launch amplitude coarse select |
| launch_fine | output | 4 | Launch amplitude fine trim |

## Verification
The hardest case to reach from the ports is the read turnaround. The register must be fetched in the same system cycle that the eighth rising SCK edge is detected, and MISO must stay released until the following falling edge. The bench reaches this by holding SCK high after the eighth header bit and sampling miso_oe before it lowers SCK. It then samples each data bit just before the next rising edge, as a master would. A write frame cut off after twelve bits checks the abort path, and mixed legal and illegal field codes check the per-field hold.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int HDR_BITS   = 1 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int NUM_SPARE  = 2;

  localparam logic [ADDR_W-1:0] A_STATUS = 7'h00;
  localparam logic [ADDR_W-1:0] A_DRIVER = 7'h01;
  localparam logic [ADDR_W-1:0] A_LAUNCH = 7'h02;
  localparam logic [ADDR_W-1:0] A_SPARE0 = 7'h03;

  localparam logic [2:0] SWING_RST = 3'b011;
  localparam logic [2:0] OFFS_RST  = 3'b001;
  localparam logic [2:0] SWING_MAX = 3'd4;
  localparam logic [2:0] OFFS_MAX  = 3'd5;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int            W      = 3,
  parameter int            STAGES = 2,
  parameter logic [W-1:0]  IDLE   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dprev
);
  logic [W-1:0] pipe [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k <= STAGES; k++) pipe[k] <= IDLE;
    end else begin
      pipe[0] <= din;
      for (int k = 1; k <= STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign dout  = pipe[STAGES-1];
  assign dprev = pipe[STAGES];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ss_n_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso_d,
  output logic              miso_oe
);
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-2:0] shreg;
  logic                  rd_frame;
  logic [DATA_W-1:0]     tx_sh;
  logic                  oe_q;

  // address is complete on the eighth rising edge, using the live MOSI bit
  assign rd_addr = {shreg[HDR_BITS-3:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      rd_frame <= 1'b0;
      tx_sh    <= '0;
      oe_q     <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (ss_n_s) begin
        bit_cnt  <= '0;
        rd_frame <= 1'b0;
        oe_q     <= 1'b0;
      end else begin
        if (sck_rise && bit_cnt < CNT_W'(FRAME_BITS)) begin
          shreg   <= {shreg[FRAME_BITS-3:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(HDR_BITS - 1) && shreg[HDR_BITS-2]) begin
            rd_frame <= 1'b1;
            tx_sh    <= rd_data;
          end
          if (bit_cnt == CNT_W'(FRAME_BITS - 1) && !shreg[FRAME_BITS-2]) begin
            wr_en   <= 1'b1;
            wr_addr <= shreg[FRAME_BITS-3:DATA_W-1];
            wr_data <= {shreg[DATA_W-2:0], mosi_s};
          end
        end
        if (sck_fall && rd_frame) begin
          if (!oe_q) oe_q  <= 1'b1;
          else       tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso_d  = tx_sh[DATA_W-1];
  assign miso_oe = oe_q;

  AST_OE_DROPS_ON_SS: assert property (@(posedge clk) disable iff (rst)
    ss_n_s |=> !oe_q); // R4
  AST_OE_ONLY_IN_READ: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> rd_frame); // R4
  AST_WR_AFTER_FULL_FRAME: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> bit_cnt == CNT_W'(FRAME_BITS)); // R9
  AST_OE_STABLE_NO_FALL: assert property (@(posedge clk) disable iff (rst)
    (!sck_fall && !ss_n_s) |=> $stable(oe_q)); // R3
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] status_in,
  output logic [2:0]        swing_code,
  output logic [2:0]        offset_code,
  output logic              launch_coarse,
  output logic [3:0]        launch_fine
);
  logic [2:0]        swing_q, offs_q;
  logic              coarse_q;
  logic [3:0]        fine_q;
  logic [DATA_W-1:0] spare_q [NUM_SPARE];

  always_ff @(posedge clk) begin
    if (rst) begin
      swing_q  <= SWING_RST;
      offs_q   <= OFFS_RST;
      coarse_q <= 1'b0;
      fine_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_DRIVER) begin
        if (wr_data[7:5] <= SWING_MAX) swing_q <= wr_data[7:5];
        if (wr_data[4:2] <= OFFS_MAX)  offs_q  <= wr_data[4:2];
      end
      if (wr_addr == A_LAUNCH) begin
        coarse_q <= wr_data[7];
        fine_q   <= wr_data[6:3];
      end
    end
  end

  for (genvar g = 0; g < NUM_SPARE; g++) begin : g_spare
    always_ff @(posedge clk) begin
      if (rst)
        spare_q[g] <= '0;
      else if (wr_en && wr_addr == A_SPARE0 + ADDR_W'(g))
        spare_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_STATUS) rd_data = status_in;
    if (rd_addr == A_DRIVER) rd_data = {swing_q, offs_q, 2'b00};
    if (rd_addr == A_LAUNCH) rd_data = {coarse_q, fine_q, 3'b000};
    for (int k = 0; k < NUM_SPARE; k++)
      if (rd_addr == A_SPARE0 + ADDR_W'(k)) rd_data = spare_q[k];
  end

  assign swing_code    = swing_q;
  assign offset_code   = offs_q;
  assign launch_coarse = coarse_q;
  assign launch_fine   = fine_q;

  AST_SWING_LEGAL: assert property (@(posedge clk) disable iff (rst)
    swing_q <= SWING_MAX); // R5
  AST_OFFSET_LEGAL: assert property (@(posedge clk) disable iff (rst)
    offs_q <= OFFS_MAX); // R5
  AST_DRIVER_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == A_DRIVER) |=> $stable(swing_q) && $stable(offs_q)); // R9
endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
  import spi_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ss_n,
  input  logic        sck,
  input  logic        mosi,
  output logic        miso_d,
  output logic        miso_oe,
  input  logic [7:0]  status_in,
  output logic [2:0]  swing_code,
  output logic [2:0]  offset_code,
  output logic        launch_coarse,
  output logic [3:0]  launch_fine
);
  logic [2:0]        pins_s, pins_p;
  logic              sck_rise, sck_fall;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en;

  spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .IDLE(3'b100)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({ss_n, sck, mosi}),
    .dout (pins_s),
    .dprev(pins_p)
  );

  assign sck_rise =  pins_s[1] & ~pins_p[1];
  assign sck_fall = ~pins_s[1] &  pins_p[1];

  spi_frame_engine i_engine (
    .clk     (clk),
    .rst     (rst),
    .ss_n_s  (pins_s[2]),
    .sck_rise(sck_rise),
    .sck_fall(sck_fall),
    .mosi_s  (pins_s[0]),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .miso_d  (miso_d),
    .miso_oe (miso_oe)
  );

  cfg_reg_file i_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .status_in    (status_in),
    .swing_code   (swing_code),
    .offset_code  (offset_code),
    .launch_coarse(launch_coarse),
    .launch_fine  (launch_fine)
  );

  AST_NO_OE_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    ($past(pins_s[2]) && pins_s[2]) |-> !miso_oe); // R4
endmodule

// File: tb/test_spi_cfg_bank.sv
module test_spi_cfg_bank;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NVEC = 21;

  // {is_read, addr, wdata, expected, requirement}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1, 7'h01, 8'h00, 8'h64, 4'd1},  // R1 reset readback
    {1'b1, 7'h02, 8'h00, 8'h00, 4'd1},
    {1'b0, 7'h01, 8'h8C, 8'h00, 4'd2},  // R2 legal write
    {1'b1, 7'h01, 8'h00, 8'h8C, 4'd2},
    {1'b0, 7'h01, 8'hFF, 8'h00, 4'd5},  // R5 both fields illegal
    {1'b1, 7'h01, 8'h00, 8'h8C, 4'd5},
    {1'b0, 7'h01, 8'hB4, 8'h00, 4'd5},  // R5 swing illegal, offset max legal
    {1'b1, 7'h01, 8'h00, 8'h94, 4'd5},
    {1'b0, 7'h02, 8'hFF, 8'h00, 4'd6},  // R6
    {1'b1, 7'h02, 8'h00, 8'hF8, 4'd6},
    {1'b0, 7'h02, 8'h5A, 8'h00, 4'd6},
    {1'b1, 7'h02, 8'h00, 8'h58, 4'd6},
    {1'b0, 7'h03, 8'hA5, 8'h00, 4'd10}, // R10
    {1'b0, 7'h04, 8'h3C, 8'h00, 4'd10},
    {1'b1, 7'h03, 8'h00, 8'hA5, 4'd10},
    {1'b1, 7'h04, 8'h00, 8'h3C, 4'd10},
    {1'b0, 7'h05, 8'h77, 8'h00, 4'd8},  // R8
    {1'b1, 7'h05, 8'h00, 8'h00, 4'd8},
    {1'b1, 7'h7F, 8'h00, 8'h00, 4'd8},
    {1'b0, 7'h00, 8'h12, 8'h00, 4'd7},  // R7
    {1'b1, 7'h00, 8'h00, 8'hC3, 4'd7}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ss_n = 1'b1;
  logic       sck = 1'b0;
  logic       mosi = 1'b0;
  logic [7:0] status_in = 8'hC3;
  logic       miso_d, miso_oe;
  logic [2:0] swing_code, offset_code;
  logic       launch_coarse;
  logic [3:0] launch_fine;

  int checks = 0;
  int errors = 0;
  logic oe_seen;
  logic oe_early;
  logic oe_lost;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cfg_bank i_spi_cfg_bank (
    .clk(clk), .rst(rst), .ss_n(ss_n), .sck(sck), .mosi(mosi),
    .miso_d(miso_d), .miso_oe(miso_oe), .status_in(status_in),
    .swing_code(swing_code), .offset_code(offset_code),
    .launch_coarse(launch_coarse), .launch_fine(launch_fine)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) begin
      @(negedge clk);
      if (miso_oe) oe_seen = 1'b1;
    end
  endtask

  task automatic spi_write(input logic [6:0] a, input logic [7:0] d, input int nbits);
    logic [15:0] fr;
    fr = {1'b0, a, d};
    oe_seen = 1'b0;
    @(negedge clk); ss_n = 1'b0;
    wait_half();
    for (int i = 0; i < nbits; i++) begin
      mosi = fr[15-i];
      wait_half();
      sck = 1'b1;
      wait_half();
      sck = 1'b0;
    end
    wait_half();
    ss_n = 1'b1;
    repeat (4) wait_half();
  endtask

  task automatic spi_read(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] hdr;
    hdr = {1'b1, a};
    oe_early = 1'b0;
    oe_lost = 1'b0;
    d = '0;
    @(negedge clk); ss_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      mosi = hdr[7-i];
      repeat (HALF) @(negedge clk);
      if (miso_oe) oe_early = 1'b1;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (miso_oe) oe_early = 1'b1;
      sck = 1'b0;
    end
    for (int j = 0; j < 8; j++) begin
      repeat (HALF) @(negedge clk);
      d[7-j] = miso_d;
      if (!miso_oe) oe_lost = 1'b1;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    ss_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    logic [27:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1 swing_code", 32'(swing_code), 32'h3);
    check("R1 offset_code", 32'(offset_code), 32'h1);
    check("R1 launch_coarse", 32'(launch_coarse), 32'h0);
    check("R1 launch_fine", 32'(launch_fine), 32'h0);
    check("R4 miso_oe idle", 32'(miso_oe), 32'h0);

    for (int n = 0; n < NVEC; n++) begin
      v = VEC[n];
      if (v[27]) begin
        spi_read(v[26:20], rd);
        check($sformatf("R%0d read vector %0d", v[3:0], n), 32'(rd), 32'(v[11:4]));
        check($sformatf("R3 oe before 8th fall, vector %0d", n), 32'(oe_early), 32'h0);
        check($sformatf("R3 oe held during data, vector %0d", n), 32'(oe_lost), 32'h0);
      end else begin
        spi_write(v[26:20], v[19:12], 16);
        check($sformatf("R4 oe during write, vector %0d", n), 32'(oe_seen), 32'h0);
      end
    end

    // R2 R5 R6 parallel outputs after the table
    check("R2 swing_code", 32'(swing_code), 32'h4);
    check("R5 offset_code", 32'(offset_code), 32'h5);
    check("R6 launch_coarse", 32'(launch_coarse), 32'h0);
    check("R6 launch_fine", 32'(launch_fine), 32'hB);

    // R9 aborted write frame after 12 bits
    spi_write(7'h01, 8'h64, 12);
    check("R9 swing after abort", 32'(swing_code), 32'h4);
    spi_read(7'h01, rd);
    check("R9 reg01 after abort", 32'(rd), 32'h94);
    spi_write(7'h03, 8'h00, 15);
    spi_read(7'h03, rd);
    check("R9 reg03 after 15-bit abort", 32'(rd), 32'hA5);

    // R7 status follows the input port
    status_in = 8'h3D;
    spi_read(7'h00, rd);
    check("R7 status live", 32'(rd), 32'h3D);

    // R8 out-of-range write left spares intact
    spi_read(7'h04, rd);
    check("R8 reg04 untouched", 32'(rd), 32'h3C);

    // R1 reset mid-run restores defaults
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 swing after reset", 32'(swing_code), 32'h3);
    check("R1 offset after reset", 32'(offset_code), 32'h1);
    check("R1 fine after reset", 32'(launch_fine), 32'h0);
    spi_read(7'h03, rd);
    check("R1 R10 reg03 after reset", 32'(rd), 32'h00);
    spi_read(7'h01, rd);
    check("R1 reg01 after reset", 32'(rd), 32'h64);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule